// File: doc/BRIEF.md
# Dual Continuous-Rotation Servo Pulse Generator

This block drives two wheel servos that have been modified to rotate continuously. Each servo's internal feedback is fixed at a dead spot, so the width of each control pulse selects one of three motions: turn clockwise, stop, or turn counterclockwise. The width does not set a position or a speed.

Each channel takes a 2-bit command and produces a pulse that repeats every frame. The output is low for the rest of each frame. All pulse lengths are whole numbers of clock cycles. They are computed at elaboration from the clock-frequency parameter and the microsecond parameters. A single frame counter is shared by every channel, so all pulses start on the same clock cycle.

A channel samples its command only on the last cycle of a frame. A command change therefore never shortens or stretches a pulse that is already running. Reset is asynchronous and active low. After reset is released, the first frame is idle, and the first pulse begins one full frame later.

Top module: `servo_pair_drv`

## Requirements
- R1: Command code 01 (bit 1 = 0, bit 0 = 1) makes the channel's pulse last CLK_HZ*CW_US/1e6 cycles (1.0 ms by default; 100 cycles with CLK_HZ = 100 kHz).
- R2: Command code 10 makes the pulse last CLK_HZ*CCW_US/1e6 cycles (2.0 ms by default; 200 cycles with CLK_HZ = 100 kHz).
- R3: Command codes 00 and 11 both make the pulse last CLK_HZ*STOP_US/1e6 cycles (1.5 ms, the dead spot; 150 cycles with CLK_HZ = 100 kHz).
- R4: Pulses repeat with a period of CLK_HZ*FRAME_US/1e6 cycles (20 ms by default; 2000 cycles with CLK_HZ = 100 kHz). The output is low for the rest of each frame.
- R5: A command is captured only on the last cycle of a frame. A change at any other time leaves the running pulse and the rest of its frame unchanged, and takes effect in the next frame.
- R6: Channel k uses cmd_i[2k+1:2k] and drives pwm_o[k]. The channels are independent, and all pulses rise on the same cycle, which is the first cycle of a frame.
- R7: While rst_ni is low, every output is low. Reset restarts the frame. After release, the first frame carries no pulse, and the first pulse rises on the FRAME-th clock edge after release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all timing is counted in its cycles |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_i | input | 2*NUM_CH | Motion command, two bits per channel |
| pwm_o | output | NUM_CH | Servo control pulse, one bit per channel |

## Verification
The assertions assume that cmd_i is synchronous to clk_i. They also assume that CLK_HZ makes the three pulse lengths nonzero, distinct and shorter than a frame, so that every pulse rises and falls inside its frame. The stimulus changes commands only at falling clock edges, and it uses a reduced CLK_HZ so that a frame takes 2000 cycles while the ratios between the lengths are kept. Reset is asserted first away from any clock edge and later in the middle of a pulse.

// File: rtl/servo_pkg.sv
`timescale 1ns/1ps
package servo_pkg;

  typedef enum logic [1:0] {
    CMD_HALT     = 2'b00,
    CMD_CW       = 2'b01,
    CMD_CCW      = 2'b10,
    CMD_HALT_ALT = 2'b11
  } servo_cmd_e;

  // Microseconds to whole clock cycles, in 64-bit arithmetic to avoid overflow.
  function automatic int us_to_cycles(input longint clk_hz, input longint us);
    return int'((clk_hz * us) / 64'd1_000_000);
  endfunction

endpackage

// File: rtl/servo_frame_timer.sv
`timescale 1ns/1ps
module servo_frame_timer #(
  parameter int FRAME_CYC = 1_000_000,
  parameter int CNT_W     = $clog2(FRAME_CYC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);

  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign wrap_o = (cnt_q == LAST);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (wrap_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  a_r4_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

  a_r4_wrap_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == LAST) |=> (cnt_q == '0));

endmodule

// File: rtl/servo_channel.sv
`timescale 1ns/1ps
module servo_channel
  import servo_pkg::*;
#(
  parameter int CNT_W    = 20,
  parameter int CW_CYC   = 50_000,
  parameter int STOP_CYC = 75_000,
  parameter int CCW_CYC  = 100_000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       cmd_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             wrap_i,
  output logic             pwm_o
);

  localparam logic [CNT_W-1:0] W_CW   = CNT_W'(CW_CYC);
  localparam logic [CNT_W-1:0] W_STOP = CNT_W'(STOP_CYC);
  localparam logic [CNT_W-1:0] W_CCW  = CNT_W'(CCW_CYC);

  logic [CNT_W-1:0] w_sel, w_q;
  logic [CNT_W:0]   cnt_nxt;
  logic             pwm_q;

  always_comb begin
    unique case (servo_cmd_e'(cmd_i))
      CMD_CW:  w_sel = W_CW;
      CMD_CCW: w_sel = W_CCW;
      default: w_sel = W_STOP;
    endcase
  end

  assign cnt_nxt = {1'b0, cnt_i} + 1'b1;

  // Width is latched only at the frame boundary; w_q = 0 gives an idle first frame.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      w_q   <= '0;
      pwm_q <= 1'b0;
    end else if (wrap_i) begin
      w_q   <= w_sel;
      pwm_q <= 1'b1;
    end else begin
      pwm_q <= (cnt_nxt < {1'b0, w_q});
    end
  end

  assign pwm_o = pwm_q;

  a_r1_width_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_q == '0) || (w_q == W_CW) || (w_q == W_STOP) || (w_q == W_CCW));

  a_r6_rise_at_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwm_q) |-> (cnt_i == '0));

  a_r5_fall_at_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwm_q) |-> (cnt_i == w_q));

endmodule

// File: rtl/servo_pair_drv.sv
`timescale 1ns/1ps
module servo_pair_drv
  import servo_pkg::*;
#(
  parameter int CLK_HZ   = 50_000_000,
  parameter int NUM_CH   = 2,
  parameter int FRAME_US = 20_000,
  parameter int CW_US    = 1_000,
  parameter int STOP_US  = 1_500,
  parameter int CCW_US   = 2_000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [2*NUM_CH-1:0] cmd_i,
  output logic [NUM_CH-1:0]   pwm_o
);

  localparam int FRAME_CYC = us_to_cycles(CLK_HZ, FRAME_US);
  localparam int CW_CYC    = us_to_cycles(CLK_HZ, CW_US);
  localparam int STOP_CYC  = us_to_cycles(CLK_HZ, STOP_US);
  localparam int CCW_CYC   = us_to_cycles(CLK_HZ, CCW_US);
  localparam int CNT_W     = $clog2(FRAME_CYC);

  logic [CNT_W-1:0] cnt;
  logic             wrap;

  servo_frame_timer #(
    .FRAME_CYC(FRAME_CYC),
    .CNT_W    (CNT_W)
  ) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cnt_o (cnt),
    .wrap_o(wrap)
  );

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    servo_channel #(
      .CNT_W   (CNT_W),
      .CW_CYC  (CW_CYC),
      .STOP_CYC(STOP_CYC),
      .CCW_CYC (CCW_CYC)
    ) u_ch (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .cmd_i (cmd_i[2*k+1:2*k]),
      .cnt_i (cnt),
      .wrap_i(wrap),
      .pwm_o (pwm_o[k])
    );
  end

  a_r7_reset_low: assert property (@(posedge clk_i)
    !rst_ni |-> (pwm_o == '0));

endmodule

// File: tb/tb_servo_pair_drv.sv
`timescale 1ns/1ps
module tb_servo_pair_drv;

  localparam int F  = 2000;  // frame cycles at 100 kHz
  localparam int W1 = 100;   // clockwise
  localparam int WS = 150;   // stop
  localparam int W2 = 200;   // counterclockwise
  localparam int NV = 7;

  // {ch1 cmd, ch0 cmd}, expected ch0 width, expected ch1 width
  localparam logic [3:0] V_CMD [NV] = '{4'b0000, 4'b1001, 4'b0110, 4'b0111, 4'b0101, 4'b1110, 4'b1000};
  localparam int         V_W0  [NV] = '{WS,      W1,      W2,      WS,      W1,      W2,      WS};
  localparam int         V_W1  [NV] = '{WS,      W2,      W1,      W1,      W1,      WS,      W2};

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b1;
  logic [3:0] cmd_i = 4'b0101;
  logic [1:0] pwm_o;

  int checks = 0;
  int fails  = 0;
  logic prev0 = 1'b0;

  always #2.5 clk_i = ~clk_i;

  servo_pair_drv #(.CLK_HZ(100_000)) dut (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cmd_i (cmd_i),
    .pwm_o (pwm_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  // Wait for the rise of channel 0, then count high samples of both channels over one frame.
  // If chg_at > 0, drive new_cmd after that many samples into the frame.
  task automatic measure(output int h0, output int h1, output int waits, output int st1,
                         input int chg_at, input logic [3:0] new_cmd);
    bit rise;
    waits = 0;
    do begin
      @(negedge clk_i);
      waits++;
      rise  = pwm_o[0] && !prev0;
      prev0 = pwm_o[0];
    end while (!rise && waits < 3*F);
    st1 = pwm_o[1];
    h0  = 1;
    h1  = pwm_o[1];
    for (int i = 1; i < F; i++) begin
      if (i == chg_at) cmd_i = new_cmd;
      @(negedge clk_i);
      h0 += pwm_o[0];
      h1 += pwm_o[1];
      prev0 = pwm_o[0];
    end
  endtask

  task automatic blank_frame();
    int hi = 0;
    for (int j = 1; j < F; j++) begin
      @(negedge clk_i);
      hi += pwm_o[0] + pwm_o[1];
      prev0 = pwm_o[0];
    end
    chk(hi == 0, "R7 idle first frame", hi, 0);
  endtask

  initial begin
    int h0, h1, wt, s1;
    #1 rst_ni = 1'b0;
    #0.5;
    chk(pwm_o == 2'b00, "R7 async reset low", pwm_o, 0);
    repeat (3) @(negedge clk_i);
    chk(pwm_o == 2'b00, "R7 reset held low", pwm_o, 0);
    rst_ni = 1'b1;
    blank_frame();

    // First frame uses cmd 0101 (both clockwise).
    measure(h0, h1, wt, s1, 0, 4'b0);
    chk(wt == 1, "R7 first pulse one frame after release", wt, 1);
    chk(h0 == W1, "R1 ch0 cw width", h0, W1);
    chk(h1 == W1, "R1 ch1 cw width", h1, W1);

    for (int v = 0; v < NV; v++) begin
      cmd_i = V_CMD[v];
      measure(h0, h1, wt, s1, 0, 4'b0);
      chk(wt == 1,  "R4 frame period", wt, 1);
      chk(s1 == 1,  "R6 common start", s1, 1);
      chk(h0 == V_W0[v], "R1/R2/R3 ch0 width", h0, V_W0[v]);
      chk(h1 == V_W1[v], "R1/R2/R3 ch1 width R6", h1, V_W1[v]);
    end

    // R5: change mid-pulse must not alter the running frame.
    cmd_i = 4'b1001;
    measure(h0, h1, wt, s1, 50, 4'b0110);
    chk(h0 == W1, "R5 ch0 not truncated", h0, W1);
    chk(h1 == W2, "R5 ch1 not cut", h1, W2);
    measure(h0, h1, wt, s1, 0, 4'b0);
    chk(h0 == W2, "R5 ch0 new cmd next frame", h0, W2);
    chk(h1 == W1, "R5 ch1 new cmd next frame", h1, W1);

    // R7: reset in the middle of a pulse.
    cmd_i = 4'b1111;
    do begin
      @(negedge clk_i);
      prev0 = pwm_o[0];
    end while (!pwm_o[0]);
    repeat (20) @(negedge clk_i);
    rst_ni = 1'b0;
    #0.5;
    chk(pwm_o == 2'b00, "R7 reset mid-pulse low", pwm_o, 0);
    @(negedge clk_i);
    prev0 = 1'b0;
    rst_ni = 1'b1;
    blank_frame();
    measure(h0, h1, wt, s1, 0, 4'b0);
    chk(wt == 1, "R7 restart frame", wt, 1);
    chk(h0 == WS && h1 == WS, "R3 code 11 stop width", h0, WS);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule